// File: doc/BRIEF.md
# Signed Divide-by-Invariant Pipeline

This block divides a stream of 32-bit two's-complement dividends by one divisor that changes rarely, and rounds each quotient toward zero. It uses no iterative divider. Software works out a signed multiplier and a shift count for the divisor once and writes them into the block's configuration registers. It also writes the divisor's sign and a flag that marks a divisor of magnitude one. Each dividend then passes through three registered steps:

- a signed multiply that keeps the upper half of the product;
- a correction that adds or subtracts the dividend, chosen by the signs of the divisor and the multiplier;
- an arithmetic right shift, followed by a +1 fix for a negative partial result.

Dividends enter on a valid/ready stream and quotients leave on a matching stream. The pipeline accepts one dividend per cycle while the consumer keeps up. When the output is stalled, the whole pipeline freezes. A divisor of magnitude one needs no multiplier, so the correction step handles it as a pass-through or a negation. Dividing the most negative dividend by minus one raises an overflow flag, and the wrapped quotient is delivered.

Top module: `sdiv_invar`

## Requirements
- R1: One clock after `rst` is sampled high, `out_valid` is 0 and `in_ready` is 1.
- R2: With `cfg_neg`=0 and `cfg_unit`=0, `out_q` equals the dividend divided by the positive divisor, truncated toward zero, for dividends of either sign.
- R3: With `cfg_neg`=1 and `cfg_unit`=0, `out_q` equals the truncated quotient by the negative divisor.
- R4: The dividend is added to the upper product half when `cfg_neg`=0 and `cfg_mult` bit 31 is 1. It is subtracted when `cfg_neg`=1 and `cfg_mult` bit 31 is 0. No correction is made otherwise. Divisors 7, 3, -7 and -3 use each case.
- R5: A `cfg_shift` of 0 skips the shift step. A nonzero value shifts the partial result right arithmetically by that many bits before the sign fix.
- R6: With `cfg_unit`=1, `out_q` is the dividend itself when `cfg_neg`=0 and the negated dividend when `cfg_neg`=1. `cfg_mult` and `cfg_shift` are then ignored.
- R7: `out_ovf` is 1 only for dividend 32'h80000000 with `cfg_unit`=1 and `cfg_neg`=1. In that case `out_q` is 32'h80000000. For every other result it is 0.
- R8: A dividend accepted on an idle pipeline appears on `out_valid` three clocks later. With `out_ready` held high, `in_ready` never drops, and no more than three items are ever in flight.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_q` and `out_ovf` keep their values on the next clock. No dividend is lost or duplicated.
- R10: A configuration written on a clock edge applies to dividends accepted after that edge. Dividends already accepted, including one accepted on the same edge, finish with the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration registers |
| cfg_mult | input | 32 | Signed multiplier for the divisor |
| cfg_shift | input | 5 | Arithmetic post-shift count |
| cfg_neg | input | 1 | Divisor is negative |
| cfg_unit | input | 1 | Divisor magnitude is one |
| in_valid | input | 1 | Dividend valid |
| in_ready | output | 1 | Block can accept a dividend |
| in_data | input | 32 | Signed dividend |
| out_valid | output | 1 | Quotient valid |
| out_ready | input | 1 | Consumer accepts the quotient |
| out_q | output | 32 | Signed quotient |
| out_ovf | output | 1 | Quotient overflowed (most negative divided by minus one) |

## Verification
The hardest case to reach from the ports is a configuration write that lands while dividends are still in flight. Items on both sides of that edge must then keep their own divisor while the output is also being stalled at random. The stimulus switches the divisor in the middle of a stream, at a fixed item index, with random input gaps and random `out_ready`. Every item is scored against a bench model that records the divisor in force on the cycle that item was accepted. The dividends also include the extremes, the divisor itself, its negation and the value one below it, so that every combination of correction and sign fix is reached.

// File: rtl/sdiv_invar_pkg.sv
package sdiv_invar_pkg;

  typedef enum logic [1:0] {
    FIX_NONE = 2'd0,
    FIX_ADD  = 2'd1,
    FIX_SUB  = 2'd2
  } fix_op_e;

endpackage

// File: rtl/sdiv_cfg_reg.sv
module sdiv_cfg_reg
  import sdiv_invar_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [W-1:0]  mult_i,
  input  logic [SW-1:0] shift_i,
  input  logic          neg_i,
  input  logic          unit_i,
  output logic [W-1:0]  mult_o,
  output logic [SW-1:0] shift_o,
  output fix_op_e       fix_o,
  output logic          neg_o,
  output logic          unit_o
);

  fix_op_e fix_dec;

  // correction choice is decided once, at write time
  always_comb begin
    if (!neg_i && mult_i[W-1])
      fix_dec = FIX_ADD;
    else if (neg_i && !mult_i[W-1])
      fix_dec = FIX_SUB;
    else
      fix_dec = FIX_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_o  <= '0;
      shift_o <= '0;
      fix_o   <= FIX_NONE;
      neg_o   <= 1'b0;
      unit_o  <= 1'b0;
    end else if (we) begin
      mult_o  <= mult_i;
      shift_o <= shift_i;
      fix_o   <= fix_dec;
      neg_o   <= neg_i;
      unit_o  <= unit_i;
    end
  end

endmodule

// File: rtl/sdiv_mul_stage.sv
module sdiv_mul_stage
  import sdiv_invar_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          v_i,
  input  logic [W-1:0]  n_i,
  input  logic [W-1:0]  mult_i,
  input  logic [SW-1:0] shift_i,
  input  fix_op_e       fix_i,
  input  logic          neg_i,
  input  logic          unit_i,
  output logic          v_o,
  output logic [W-1:0]  hi_o,
  output logic [W-1:0]  n_o,
  output logic [SW-1:0] shift_o,
  output fix_op_e       fix_o,
  output logic          neg_o,
  output logic          unit_o
);

  logic signed [2*W-1:0] prod;
  logic [W-1:0]          hi_c;

  assign prod = $signed(mult_i) * $signed(n_i);
  assign hi_c = W'(prod >>> W);

  always_ff @(posedge clk) begin
    if (rst)
      v_o <= 1'b0;
    else if (en)
      v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      hi_o    <= hi_c;
      n_o     <= n_i;
      shift_o <= shift_i;
      fix_o   <= fix_i;
      neg_o   <= neg_i;
      unit_o  <= unit_i;
    end
  end

endmodule

// File: rtl/sdiv_fix_stage.sv
module sdiv_fix_stage
  import sdiv_invar_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          v_i,
  input  logic [W-1:0]  hi_i,
  input  logic [W-1:0]  n_i,
  input  logic [SW-1:0] shift_i,
  input  fix_op_e       fix_i,
  input  logic          neg_i,
  input  logic          unit_i,
  output logic          v_o,
  output logic [W-1:0]  part_o,
  output logic [SW-1:0] shift_o,
  output logic          unit_o,
  output logic          ovf_o
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] part_c;
  logic         ovf_c;

  always_comb begin
    ovf_c = 1'b0;
    if (unit_i) begin
      part_c = neg_i ? (~n_i + 1'b1) : n_i;
      ovf_c  = neg_i && (n_i == MOST_NEG);
    end else begin
      unique case (fix_i)
        FIX_ADD: part_c = hi_i + n_i;
        FIX_SUB: part_c = hi_i - n_i;
        default: part_c = hi_i;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      v_o <= 1'b0;
    else if (en)
      v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      part_o  <= part_c;
      shift_o <= shift_i;
      unit_o  <= unit_i;
      ovf_o   <= ovf_c;
    end
  end

endmodule

// File: rtl/sdiv_shift_stage.sv
module sdiv_shift_stage #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          v_i,
  input  logic [W-1:0]  part_i,
  input  logic [SW-1:0] shift_i,
  input  logic          unit_i,
  input  logic          ovf_i,
  output logic          v_o,
  output logic [W-1:0]  q_o,
  output logic          ovf_o
);

  logic signed [W-1:0] shifted;
  logic [W-1:0]        q_c;

  assign shifted = $signed(part_i) >>> shift_i;

  // sign bit added back makes the result round toward zero
  always_comb begin
    if (unit_i)
      q_c = part_i;
    else
      q_c = shifted + {{(W-1){1'b0}}, shifted[W-1]};
  end

  always_ff @(posedge clk) begin
    if (rst)
      v_o <= 1'b0;
    else if (en)
      v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      q_o   <= q_c;
      ovf_o <= ovf_i;
    end
  end

endmodule

// File: rtl/sdiv_invar.sv
module sdiv_invar
  import sdiv_invar_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [W-1:0]         cfg_mult,
  input  logic [$clog2(W)-1:0] cfg_shift,
  input  logic                 cfg_neg,
  input  logic                 cfg_unit,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_q,
  output logic                 out_ovf
);

  localparam int SW = $clog2(W);

  logic          adv;

  logic [W-1:0]  c_mult;
  logic [SW-1:0] c_shift;
  fix_op_e       c_fix;
  logic          c_neg;
  logic          c_unit;

  logic          s1_v;
  logic [W-1:0]  s1_hi;
  logic [W-1:0]  s1_n;
  logic [SW-1:0] s1_shift;
  fix_op_e       s1_fix;
  logic          s1_neg;
  logic          s1_unit;

  logic          s2_v;
  logic [W-1:0]  s2_part;
  logic [SW-1:0] s2_shift;
  logic          s2_unit;
  logic          s2_ovf;

  // whole pipe moves together unless the output slot is held
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  sdiv_cfg_reg #(.W(W), .SW(SW)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .mult_i  (cfg_mult),
    .shift_i (cfg_shift),
    .neg_i   (cfg_neg),
    .unit_i  (cfg_unit),
    .mult_o  (c_mult),
    .shift_o (c_shift),
    .fix_o   (c_fix),
    .neg_o   (c_neg),
    .unit_o  (c_unit)
  );

  sdiv_mul_stage #(.W(W), .SW(SW)) u_mul (
    .clk     (clk),
    .rst     (rst),
    .en      (adv),
    .v_i     (in_valid),
    .n_i     (in_data),
    .mult_i  (c_mult),
    .shift_i (c_shift),
    .fix_i   (c_fix),
    .neg_i   (c_neg),
    .unit_i  (c_unit),
    .v_o     (s1_v),
    .hi_o    (s1_hi),
    .n_o     (s1_n),
    .shift_o (s1_shift),
    .fix_o   (s1_fix),
    .neg_o   (s1_neg),
    .unit_o  (s1_unit)
  );

  sdiv_fix_stage #(.W(W), .SW(SW)) u_fix (
    .clk     (clk),
    .rst     (rst),
    .en      (adv),
    .v_i     (s1_v),
    .hi_i    (s1_hi),
    .n_i     (s1_n),
    .shift_i (s1_shift),
    .fix_i   (s1_fix),
    .neg_i   (s1_neg),
    .unit_i  (s1_unit),
    .v_o     (s2_v),
    .part_o  (s2_part),
    .shift_o (s2_shift),
    .unit_o  (s2_unit),
    .ovf_o   (s2_ovf)
  );

  sdiv_shift_stage #(.W(W), .SW(SW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .en      (adv),
    .v_i     (s2_v),
    .part_i  (s2_part),
    .shift_i (s2_shift),
    .unit_i  (s2_unit),
    .ovf_i   (s2_ovf),
    .v_o     (out_valid),
    .q_o     (out_q),
    .ovf_o   (out_ovf)
  );

endmodule

// File: rtl/sdiv_invar_chk.sv
module sdiv_invar_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_q,
  input logic         out_ovf
);

  logic [2:0] inflight;

  always_ff @(posedge clk) begin
    if (rst)
      inflight <= '0;
    else
      inflight <= inflight + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> !out_valid);

  // R7
  ovf_value_chk: assert property (@(posedge clk) disable iff (rst)
    out_ovf && out_valid |-> out_q == {1'b1, {(W-1){1'b0}}});

  // R8
  inflight_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= 3'd3);

  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_q) && $stable(out_ovf));

  // R9
  valid_has_item_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight != 3'd0);

endmodule

bind sdiv_invar sdiv_invar_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_q     (out_q),
  .out_ovf   (out_ovf)
);

// File: tb/tb_sdiv_invar.sv
module tb_sdiv_invar;

  localparam int MOST_NEG = 32'sh8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_mult = '0;
  logic [4:0]  cfg_shift = '0;
  logic        cfg_neg = 1'b0;
  logic        cfg_unit = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_q;
  logic        out_ovf;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [32:0] expq[$];

  always #2 clk = ~clk;

  sdiv_invar dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mult(cfg_mult),
    .cfg_shift(cfg_shift), .cfg_neg(cfg_neg), .cfg_unit(cfg_unit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_q(out_q),
    .out_ovf(out_ovf)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic void magic(input int d, output logic [31:0] m, output logic [4:0] s);
    longint unsigned two31, ad, t, anc, q1, r1, q2, r2, delta;
    longint sd;
    int p;
    two31 = 64'h8000_0000;
    sd = d;
    ad = (sd < 0) ? longint'(-sd) : longint'(sd);
    t = two31 + ((d < 0) ? 64'd1 : 64'd0);
    anc = t - 1 - (t % ad);
    p = 31;
    q1 = two31 / anc;  r1 = two31 - q1 * anc;
    q2 = two31 / ad;   r2 = two31 - q2 * ad;
    do begin
      p = p + 1;
      q1 = (2 * q1) & 64'hFFFF_FFFF;  r1 = (2 * r1) & 64'hFFFF_FFFF;
      if (r1 >= anc) begin q1 = q1 + 1; r1 = r1 - anc; end
      q2 = (2 * q2) & 64'hFFFF_FFFF;  r2 = (2 * r2) & 64'hFFFF_FFFF;
      if (r2 >= ad) begin q2 = q2 + 1; r2 = r2 - ad; end
      delta = ad - r2;
    end while (q1 < delta || (q1 == delta && r1 == 0));
    m = 32'(q2 + 1);
    if (d < 0) m = -m;
    s = 5'(p - 32);
  endfunction

  function automatic logic [32:0] ref_q(input int n, input int d);
    if (d == -1 && n == MOST_NEG) return {1'b1, 32'h8000_0000};
    return {1'b0, 32'(n / d)};
  endfunction

  task automatic put_cfg(input int d);
    logic [31:0] m;
    logic [4:0]  s;
    cfg_we   = 1'b1;
    cfg_neg  = (d < 0);
    cfg_unit = (d == 1 || d == -1);
    if (d == 1 || d == -1) begin
      cfg_mult = '0; cfg_shift = '0;
    end else begin
      magic(d, m, s);
      cfg_mult = m; cfg_shift = s;
    end
  endtask

  task automatic set_cfg_idle(input int d);
    @(negedge clk);
    put_cfg(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int pick(input int i, input int d);
    case (i % 10)
      0: return MOST_NEG;
      1: return 32'sh7FFF_FFFF;
      2: return 0;
      3: return -1;
      4: return 1;
      5: return d;
      6: return -d;
      7: return d - 1;
      default: return int'($urandom);
    endcase
  endfunction

  // R2 R3 R4 R5 R6 R7 R9 R10 scored per item; returns input stalls seen
  task automatic stream(input int count, input int d_a, input int d_b, input int sw,
                        input int rdy_pct, input int vld_pct, output int in_stalls);
    int sent = 0;
    int cur_d = d_a;
    bit sw_done = 0;
    bit pv = 0, pr = 0, pov = 0;
    logic [31:0] pq = '0;
    logic [32:0] e;
    in_stalls = 0;
    while (sent < count || expq.size() > 0) begin
      @(negedge clk);
      if (pv && !pr)
        check(out_valid && out_q == pq && out_ovf == pov, "R9", "held output",
              {out_valid, out_q}, {1'b1, pq});
      cfg_we = 1'b0;
      if (sent == sw && !sw_done) begin
        put_cfg(d_b);
        sw_done = 1;
      end
      out_ready = (($urandom % 100) < rdy_pct);
      if (sent < count && (($urandom % 100) < vld_pct)) begin
        in_valid = 1'b1;
        in_data  = pick(sent, cur_d);
      end else
        in_valid = 1'b0;
      #1;
      if (in_valid && !in_ready) in_stalls++;
      if (in_valid && in_ready) begin
        expq.push_back(ref_q(int'(in_data), cur_d));
        sent++;
      end
      if (cfg_we) cur_d = d_b;
      if (out_valid && out_ready) begin
        if (expq.size() == 0)
          check(0, "R9", "extra output", out_q, 0);
        else begin
          e = expq.pop_front();
          check({out_ovf, out_q} == e, "R2/R3/R6/R7/R10", "quotient", {out_ovf, out_q}, e);
        end
      end
      pv = out_valid; pr = out_ready; pq = out_q; pov = out_ovf;
    end
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b0;
  endtask

  initial begin
    int st;
    int lat;
    repeat (3) @(negedge clk);
    // R1
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    rst = 1'b0;

    // R8: latency on an idle pipeline
    set_cfg_idle(7);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_data   = 32'd100;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 3, "R8", "latency", lat, 3);
    check(out_q == 32'd14, "R2", "100/7", out_q, 14);
    @(negedge clk);

    // R4 R5: each correction case, with and without shift
    set_cfg_idle(7);   stream(60, 7, 7, -1, 70, 80, st);
    set_cfg_idle(3);   stream(60, 3, 3, -1, 70, 80, st);
    set_cfg_idle(-7);  stream(60, -7, -7, -1, 70, 80, st);
    set_cfg_idle(-3);  stream(60, -3, -3, -1, 70, 80, st);
    set_cfg_idle(2);   stream(40, 2, 2, -1, 60, 90, st);
    set_cfg_idle(1000003); stream(40, 1000003, 1000003, -1, 60, 90, st);
    set_cfg_idle(-65536);  stream(40, -65536, -65536, -1, 60, 90, st);
    set_cfg_idle(MOST_NEG); stream(30, MOST_NEG, MOST_NEG, -1, 60, 90, st);
    set_cfg_idle(32'sh7FFF_FFFF); stream(30, 32'sh7FFF_FFFF, 32'sh7FFF_FFFF, -1, 60, 90, st);

    // R6 R7: unit divisors, including the overflow case
    set_cfg_idle(1);  stream(30, 1, 1, -1, 60, 90, st);
    set_cfg_idle(-1); stream(30, -1, -1, -1, 60, 90, st);

    // R10: divisor switched mid-stream with items in flight
    set_cfg_idle(13); stream(80, 13, -9, 37, 50, 100, st);
    set_cfg_idle(-1); stream(40, -1, 5, 20, 40, 100, st);

    // R8: full throughput with the consumer always ready
    set_cfg_idle(11); stream(200, 11, 11, -1, 100, 100, st);
    check(st == 0, "R8", "input stalls at full rate", st, 0);

    // random divisors
    for (int k = 0; k < 20; k++) begin
      int d;
      d = int'($urandom) >>> ($urandom % 30);
      if (d == 0 || d == 1 || d == -1) d = 37;
      set_cfg_idle(d);
      stream(40, d, d, -1, 75, 85, st);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end

endmodule